// File: doc/BRIEF.md
# Interleaved Block Refill Controller

This controller fetches one four-word cache block from four word-wide memory banks and hands the words back over a single-word response bus. The words of a block are spread across the banks, with word i stored in bank i. Each bank therefore holds a quarter of memory and is addressed by the block address alone. The surrounding system gives a block address and a mode bit. The controller drives a shared bank address and per-bank enable strobes, waits out the fixed bank access time, and then returns the words in order 0 to 3. Each returned word carries its index, a valid strobe, and a final-word flag on word 3.

The controller has two modes. In interleaved mode it starts all four banks in the same cycle, so their access times overlap. A refill then costs 1 address cycle, 40 access cycles and 4 transfer cycles, 45 cycles in all. In sequential mode each word is a separate access of 1 + 40 + 1 cycles, and the block takes 168 cycles. The mode exists so that both costs can be measured on the same hardware. A bank delivers its word only during the last cycle of its access window, so the controller captures bank data on a fixed count and does not use a bank handshake.

Top module: `ilv_refill_ctrl`

## Requirements
- R1: A synchronous reset, applied at any time including mid-refill, leaves `busy`, `bank_en`, `rsp_valid` and `rsp_last` at 0 after the reset edge.
- R2: When idle, a high `req_valid` at a rising edge accepts the request. From that edge `busy` is 1 and `bank_addr` equals `req_blk`. `bank_addr` keeps that value until the next acceptance.
- R3: With `mode_ilv` = 1 at acceptance, `bank_en` is 4'b1111 for exactly the one cycle after the accepting edge, and 0 for the rest of the refill.
- R4: With `mode_ilv` = 0 at acceptance, `bank_en` is one-hot. It selects bank k (bit k) for one cycle starting 42·k edges after the accepting edge, for k = 0..3, and is 0 otherwise.
- R5: In interleaved mode, `rsp_valid` is 1 after edges 41, 42, 43 and 44 counted from the accepting edge, carrying words 0..3. It is 0 at all other times of the refill, so the block occupies 45 cycles.
- R6: In sequential mode, `rsp_valid` is 1 for a single cycle after edge 42·k+41 for word k, and 0 otherwise, so word 3 appears in cycle 168.
- R7: Word k carries the value bank k presented on its data lanes (bits 32k+31..32k) in the 40th cycle after that bank's enable cycle.
- R8: `rsp_word` gives the index of the presented word. `rsp_last` is 1 only together with word 3.
- R9: `busy` falls in the same cycle the final word is presented. A request held high at the following edge is accepted there, and `rsp_valid` is 0 in the cycle after that edge.
- R10: `req_valid` and `req_blk` are ignored while `busy` is 1: `bank_addr`, `bank_en` and the response sequence are unaffected.
- R11: The mode is sampled only at acceptance. Changing `mode_ilv` during a refill does not alter its enables, timing or data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Refill request strobe |
| req_blk | input | 12 | Block address (bank-local word address) |
| mode_ilv | input | 1 | 1 = interleaved, 0 = sequential; sampled at acceptance |
| busy | output | 1 | Refill in progress |
| bank_en | output | 4 | Per-bank access start strobe |
| bank_addr | output | 12 | Address shared by all banks |
| bank_rdata | input | 128 | Bank read data, bank k on bits 32k+31..32k |
| rsp_valid | output | 1 | Response word valid |
| rsp_data | output | 32 | Response word |
| rsp_word | output | 2 | Index of the response word |
| rsp_last | output | 1 | Marks word 3 |

## Verification
Two events can share a cycle: the final word leaving on the response bus and the acceptance of the next refill, because `busy` drops while word 3 is still presented. The bench keeps a new request waiting at that point in both modes. It then checks that the new enables appear exactly one edge later, that `rsp_valid` is already low, and that the earlier block's data and flags were complete. A second overlap is a new request, or a mode flip, arriving in the middle of an access window. This is judged by checking the whole enable, address and response sequence cycle by cycle against the undisturbed expectation.

// File: rtl/ilv_refill_pkg.sv
package ilv_refill_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_WAIT,
    ST_GAP,
    ST_XFER
  } refill_state_t;
endpackage

// File: rtl/ilv_refill_fsm.sv
module ilv_refill_fsm
  import ilv_refill_pkg::*;
#(
  parameter int BLK_W      = 12,
  parameter int NUM_BANKS  = 4,
  parameter int ACCESS_LAT = 40,
  localparam int SEL_W     = $clog2(NUM_BANKS),
  localparam int CNT_W     = $clog2(ACCESS_LAT)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 req_valid,
  input  logic [BLK_W-1:0]     req_blk,
  input  logic                 mode_ilv,
  output logic                 busy,
  output logic [NUM_BANKS-1:0] bank_en,
  output logic [BLK_W-1:0]     bank_addr,
  output logic                 rsp_valid,
  output logic [SEL_W-1:0]     rsp_word,
  output logic                 rsp_last,
  output logic                 cap,
  output logic                 cap_all,
  output logic                 emit,
  output logic [SEL_W-1:0]     word_idx
);
  localparam logic [SEL_W-1:0] LAST_WORD = SEL_W'(NUM_BANKS - 1);
  localparam logic [CNT_W-1:0] WAIT_LOAD = CNT_W'(ACCESS_LAT - 1);

  refill_state_t    state_q;
  logic [CNT_W-1:0] cnt_q;
  logic [SEL_W-1:0] word_q;
  logic             ilv_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      cnt_q     <= '0;
      word_q    <= '0;
      ilv_q     <= 1'b0;
      bank_en   <= '0;
      bank_addr <= '0;
      rsp_valid <= 1'b0;
      rsp_word  <= '0;
      rsp_last  <= 1'b0;
    end else begin
      bank_en   <= '0;
      rsp_valid <= 1'b0;
      rsp_last  <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (req_valid) begin
            bank_addr <= req_blk;
            ilv_q     <= mode_ilv;
            word_q    <= '0;
            bank_en   <= mode_ilv ? {NUM_BANKS{1'b1}} : NUM_BANKS'(1);
            state_q   <= ST_ADDR;
          end
        end
        ST_ADDR: begin
          cnt_q   <= WAIT_LOAD;
          state_q <= ST_WAIT;
        end
        ST_WAIT: begin
          if (cnt_q == '0) begin
            rsp_valid <= 1'b1;
            rsp_word  <= word_q;
            rsp_last  <= (word_q == LAST_WORD);
            if (ilv_q) begin
              word_q  <= word_q + 1'b1;
              state_q <= ST_XFER;
            end else if (word_q == LAST_WORD) begin
              state_q <= ST_IDLE;
            end else begin
              word_q  <= word_q + 1'b1;
              state_q <= ST_GAP;
            end
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        ST_GAP: begin
          bank_en <= NUM_BANKS'(1) << word_q;
          state_q <= ST_ADDR;
        end
        ST_XFER: begin
          rsp_valid <= 1'b1;
          rsp_word  <= word_q;
          rsp_last  <= (word_q == LAST_WORD);
          word_q    <= word_q + 1'b1;
          if (word_q == LAST_WORD) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy     = (state_q != ST_IDLE);
  assign cap      = (state_q == ST_WAIT) && (cnt_q == '0);
  assign cap_all  = cap && ilv_q;
  assign emit     = (state_q == ST_XFER);
  assign word_idx = word_q;

  // R3: a full-width start in interleaved mode, never a partial one
  a_r3_all_banks: assert property (@(posedge clk) disable iff (rst)
    (bank_en != '0 && ilv_q) |-> (&bank_en));
  // R3: every start strobe lasts exactly one cycle
  a_r3_en_pulse: assert property (@(posedge clk) disable iff (rst)
    (bank_en != '0) |=> (bank_en == '0));
  // R4: sequential mode starts one bank at a time
  a_r4_seq_onehot: assert property (@(posedge clk) disable iff (rst)
    (bank_en != '0 && !ilv_q) |-> ($countones(bank_en) == 1));
  // R5: interleaved words leave back to back with rising index
  a_r5_burst_contig: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_last && ilv_q) |=>
      (rsp_valid && rsp_word == SEL_W'($past(rsp_word) + 1'b1)));
  // R8: the final-word flag travels only with the top word
  a_r8_last_word: assert property (@(posedge clk) disable iff (rst)
    rsp_last |-> (rsp_valid && rsp_word == LAST_WORD));
  // R10: the bank address cannot move while a refill runs
  a_r10_addr_hold: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(bank_addr));
  // R6: the wait counter never leaves its window
  a_r6_cnt_range: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= WAIT_LOAD);
endmodule

// File: rtl/ilv_word_buf.sv
module ilv_word_buf #(
  parameter int DATA_W    = 32,
  parameter int NUM_BANKS = 4,
  localparam int SEL_W    = $clog2(NUM_BANKS)
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [NUM_BANKS*DATA_W-1:0] bank_rdata,
  input  logic                        cap,
  input  logic                        cap_all,
  input  logic                        emit,
  input  logic [SEL_W-1:0]            word_idx,
  output logic [DATA_W-1:0]           rsp_data
);
  logic [DATA_W-1:0] lane  [NUM_BANKS];
  logic [DATA_W-1:0] store [NUM_BANKS];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_lane
    assign lane[b] = bank_rdata[b*DATA_W +: DATA_W];
    always_ff @(posedge clk) begin
      if (cap_all) store[b] <= lane[b];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_data <= '0;
    end else if (cap) begin
      rsp_data <= lane[word_idx];
    end else if (emit) begin
      rsp_data <= store[word_idx];
    end
  end

  // R7: the response word only changes on a capture or a transfer step
  a_r7_data_hold: assert property (@(posedge clk) disable iff (rst)
    (!cap && !emit) |=> $stable(rsp_data));
endmodule

// File: rtl/ilv_refill_ctrl.sv
module ilv_refill_ctrl #(
  parameter int DATA_W     = 32,
  parameter int BLK_W      = 12,
  parameter int NUM_BANKS  = 4,
  parameter int ACCESS_LAT = 40,
  localparam int SEL_W     = $clog2(NUM_BANKS)
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        req_valid,
  input  logic [BLK_W-1:0]            req_blk,
  input  logic                        mode_ilv,
  output logic                        busy,
  output logic [NUM_BANKS-1:0]        bank_en,
  output logic [BLK_W-1:0]            bank_addr,
  input  logic [NUM_BANKS*DATA_W-1:0] bank_rdata,
  output logic                        rsp_valid,
  output logic [DATA_W-1:0]           rsp_data,
  output logic [SEL_W-1:0]            rsp_word,
  output logic                        rsp_last
);
  logic             cap;
  logic             cap_all;
  logic             emit;
  logic [SEL_W-1:0] word_idx;

  ilv_refill_fsm #(
    .BLK_W      (BLK_W),
    .NUM_BANKS  (NUM_BANKS),
    .ACCESS_LAT (ACCESS_LAT)
  ) u_fsm (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_blk   (req_blk),
    .mode_ilv  (mode_ilv),
    .busy      (busy),
    .bank_en   (bank_en),
    .bank_addr (bank_addr),
    .rsp_valid (rsp_valid),
    .rsp_word  (rsp_word),
    .rsp_last  (rsp_last),
    .cap       (cap),
    .cap_all   (cap_all),
    .emit      (emit),
    .word_idx  (word_idx)
  );

  ilv_word_buf #(
    .DATA_W    (DATA_W),
    .NUM_BANKS (NUM_BANKS)
  ) u_buf (
    .clk        (clk),
    .rst        (rst),
    .bank_rdata (bank_rdata),
    .cap        (cap),
    .cap_all    (cap_all),
    .emit       (emit),
    .word_idx   (word_idx),
    .rsp_data   (rsp_data)
  );
endmodule

// File: tb/ilv_refill_ctrl_test.sv
module ilv_refill_ctrl_test;
  localparam int DW  = 32;
  localparam int BW  = 12;
  localparam int NB  = 4;
  localparam int LAT = 40;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           req_valid = 1'b0;
  logic [BW-1:0]  req_blk = '0;
  logic           mode_ilv = 1'b0;
  logic           busy;
  logic [NB-1:0]  bank_en;
  logic [BW-1:0]  bank_addr;
  logic [NB*DW-1:0] bank_rdata = {NB{32'hDEAD_BEEF}};
  logic           rsp_valid;
  logic [DW-1:0]  rsp_data;
  logic [1:0]     rsp_word;
  logic           rsp_last;

  int n_chk = 0;
  int n_bad = 0;

  ilv_refill_ctrl uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_blk(req_blk),
    .mode_ilv(mode_ilv), .busy(busy), .bank_en(bank_en),
    .bank_addr(bank_addr), .bank_rdata(bank_rdata), .rsp_valid(rsp_valid),
    .rsp_data(rsp_data), .rsp_word(rsp_word), .rsp_last(rsp_last)
  );

  always #5 clk = ~clk;

  function automatic logic [DW-1:0] mem_word(int b, logic [BW-1:0] a);
    return {4'(b + 1), 4'hC, 12'h000, a};
  endfunction

  // bank model: word visible only in the 40th cycle after its start strobe
  logic [BW-1:0] bank_la [NB];
  int            bank_cd [NB];
  initial for (int b = 0; b < NB; b++) begin bank_cd[b] = 0; bank_la[b] = '0; end

  always @(posedge clk) begin
    for (int b = 0; b < NB; b++) begin
      if (bank_en[b]) begin
        bank_cd[b] <= LAT - 1;
        bank_la[b] <= bank_addr;
      end else if (bank_cd[b] != 0) begin
        bank_cd[b] <= bank_cd[b] - 1;
      end
      bank_rdata[b*DW +: DW] <= (!bank_en[b] && bank_cd[b] == 1) ?
                                mem_word(b, bank_la[b]) : 32'hDEAD_BEEF;
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  // issues a request at the current negedge and checks every cycle to the last word
  task automatic run_block(input logic ilv, input logic [BW-1:0] blk,
                           input bit flip, input bit poke);
    int last;
    string t_en, t_v, t_a;
    last = ilv ? 44 : 167;
    t_en = flip ? "R11 bank_en" : (ilv ? "R3 bank_en" : "R4 bank_en");
    t_v  = flip ? "R11 rsp_valid" : (ilv ? "R5 rsp_valid" : "R6 rsp_valid");
    t_a  = poke ? "R10 bank_addr" : "R2 bank_addr";
    req_valid = 1'b1;
    req_blk   = blk;
    mode_ilv  = ilv;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    req_blk   = ~blk;
    for (int e = 0; e <= last; e++) begin
      logic [3:0] exp_en;
      logic       exp_v;
      int         k;
      if (e > 0) begin
        @(posedge clk);
        @(negedge clk);
      end
      if (ilv) begin
        exp_en = (e == 0) ? 4'hF : 4'h0;
        exp_v  = (e >= 41 && e <= 44);
        k      = e - 41;
      end else begin
        exp_en = (e % 42 == 0) ? 4'(1 << (e / 42)) : 4'h0;
        exp_v  = (e % 42 == 41);
        k      = e / 42;
      end
      chk(t_en, 64'(bank_en), 64'(exp_en));
      chk(t_v, 64'(rsp_valid), 64'(exp_v));
      chk(t_a, 64'(bank_addr), 64'(blk));
      chk("R9 busy", 64'(busy), 64'(e < last));
      if (exp_v) begin
        chk("R7 rsp_data", 64'(rsp_data), 64'(mem_word(k, blk)));
        chk("R8 rsp_word", 64'(rsp_word), 64'(k));
        chk("R8 rsp_last", 64'(rsp_last), 64'(k == 3));
      end else begin
        chk("R8 rsp_last idle", 64'(rsp_last), 64'd0);
      end
      if (flip && e == 5) mode_ilv = ~ilv;
      if (poke && e >= 10 && e <= 12) begin
        req_valid = 1'b1;
        req_blk   = blk ^ 12'hA5A;
      end
      if (poke && e == 13) req_valid = 1'b0;
    end
  endtask

  task automatic idle_gap();
    @(posedge clk);
    @(negedge clk);
    chk("R9 valid after last", 64'(rsp_valid), 64'd0);
    chk("R9 idle busy", 64'(busy), 64'd0);
    chk("R9 idle bank_en", 64'(bank_en), 64'd0);
  endtask

  // {interleaved, mode flip, busy poke, block address}
  localparam logic [14:0] VEC [7] = '{
    {1'b1, 1'b0, 1'b0, 12'h123},
    {1'b0, 1'b0, 1'b0, 12'h456},
    {1'b1, 1'b0, 1'b0, 12'hFFF},
    {1'b0, 1'b0, 1'b0, 12'h000},
    {1'b1, 1'b1, 1'b1, 12'h7A5},
    {1'b0, 1'b1, 1'b1, 12'h2B8},
    {1'b1, 1'b0, 1'b0, 12'h345}
  };

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL R5 watchdog actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 busy", 64'(busy), 64'd0);
    chk("R1 bank_en", 64'(bank_en), 64'd0);
    chk("R1 rsp_valid", 64'(rsp_valid), 64'd0);
    chk("R1 rsp_last", 64'(rsp_last), 64'd0);
    rst = 1'b0;
    idle_gap();

    for (int i = 0; i < 7; i++) begin
      run_block(VEC[i][14], VEC[i][11:0], VEC[i][13], VEC[i][12]);
      idle_gap();
    end

    // R9: next request waits at the final-word cycle, both orders of modes
    run_block(1'b1, 12'h111, 1'b0, 1'b0);
    run_block(1'b0, 12'h222, 1'b0, 1'b0);
    run_block(1'b1, 12'h333, 1'b0, 1'b0);
    idle_gap();

    // R1: reset in the middle of an access window
    req_valid = 1'b1;
    req_blk   = 12'h5C3;
    mode_ilv  = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    repeat (20) begin
      @(posedge clk);
      @(negedge clk);
    end
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk("R1 mid busy", 64'(busy), 64'd0);
    chk("R1 mid bank_en", 64'(bank_en), 64'd0);
    chk("R1 mid rsp_valid", 64'(rsp_valid), 64'd0);
    chk("R1 mid rsp_last", 64'(rsp_last), 64'd0);
    rst = 1'b0;
    repeat (45) idle_gap();
    run_block(1'b0, 12'h9E1, 1'b0, 1'b0);
    idle_gap();

    summary();
    $finish;
  end
endmodule